// File: doc/BRIEF.md
# Exception State and Priority Controller

This block keeps the service state of every exception source of a small processor core and picks the source that the core should take next. The sources are a non-maskable interrupt, a hard fault, three configurable faults (memory access, bus, usage) and a parameterised group of peripheral interrupts. Each source is held in one of four states. Hardware request pulses and software set-pending strobes drive a source towards pending. Handler-entry and exception-return strobes from the core move it through active and back.

A combinational arbiter reads the registered state. It reports the most urgent pending source that is allowed to run and the current execution priority, which comes from the most urgent active source. It raises a preempt request when the winner is strictly more urgent than that level. A fault raised while its own source is disabled is redirected to the hard fault. After reset is released, a single-cycle strobe tells the core to start the reset handler in privileged thread mode.

Source indices, which are also the exception order used for ties: 0 non-maskable interrupt, 1 hard fault, 2 memory access fault, 3 bus fault, 4 usage fault, 5 and up peripheral interrupts.

Top module: `esc_ctrl`

## Requirements
- R1: Each source reports a 2-bit state on `state[2*i+:2]`: 00 inactive, 01 pending, 10 active, 11 active-and-pending. After reset every source is 00.
- R2: A pulse on `hw_req[i]` or `sw_set[i]` moves an inactive source to 01. A further request while the source is pending leaves it at 01.
- R3: A request to a source in state 10 moves it to 11.
- R4: `entry_stb` with `entry_id` = i clears the pending flag of source i and sets its active flag in the next cycle.
- R5: `ret_stb` with `ret_id` = i clears the active flag of source i. State 10 becomes 00, and state 11 becomes 01.
- R6: Entering a second handler while another is active leaves both sources in state 10. `exec_rank` then follows the most urgent active source and falls back to the outer one when the inner one returns.
- R7: Urgency ranks are: NMI 0, hard fault 1, and a configurable source with 3-bit priority p has rank p+2, where lower is more urgent. `win_id` is the pending, enabled source with the lowest rank, and the lower index wins a tie. A disabled interrupt that is pending is not chosen, but it stays in state 01.
- R8: `exec_rank` is the lowest rank among active sources, or 10 when none is active. `preempt_req` is high only when `win_valid` is set and the winner's rank is strictly below `exec_rank`.
- R9: NMI and hard fault ignore `src_en`. While NMI is active, nothing raises `preempt_req`.
- R10: A request to a fault source (index 2, 3 or 4) whose `src_en` bit is 0 leaves that source unchanged and makes the hard fault pending.
- R11: `hw_req[2]` counts only while `prot_en` is 1. `xn_fetch` makes the memory access fault pending whatever the value of `prot_en`.
- R12: `rst_n` is asynchronous and is released through two synchronising flops. `reset_entry` is high for exactly one cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | N | Per-source hardware request pulses |
| sw_set | input | N | Per-source software set-pending strobes |
| xn_fetch | input | 1 | Fetch from an execute-never region |
| prot_en | input | 1 | Memory protection unit enabled |
| src_en | input | N | Per-source enable; bits 0 and 1 are ignored |
| prio | input | N*PW | Per-source priority fields; fields 0 and 1 are ignored |
| entry_stb | input | 1 | Core enters a handler |
| entry_id | input | IW | Source being entered |
| ret_stb | input | 1 | Core returns from a handler |
| ret_id | input | IW | Source returning |
| state | output | 2*N | Per-source state |
| win_valid | output | 1 | An eligible pending source exists |
| win_id | output | IW | Winning pending source |
| preempt_req | output | 1 | Winner is more urgent than the execution level |
| exec_rank | output | PW+1 | Current execution priority rank |
| reset_entry | output | 1 | One-cycle start of the reset handler |

## Verification
The bench targets the urgency comparison at equal rank. A design that used less-or-equal would preempt a running handler with a new request of the same level, or pick the higher-numbered source on a tie. The bench also drives a request into a handler that is already running and then returns from it. A design that dropped the second request would go back to inactive instead of pending. Other tests raise faults on disabled sources, a protection fault with protection off, and an execute-never fetch. Wrong escalation or gating there leaves the hard fault idle or sets the wrong fault pending. Nesting and NMI tests check that the execution level tracks the innermost active source and that nothing preempts an active NMI.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_ACT_PEND = 2'b11
  } esc_state_e;

  localparam int unsigned SRC_NMI       = 0;
  localparam int unsigned SRC_HARD      = 1;
  localparam int unsigned SRC_MEM       = 2;
  localparam int unsigned SRC_BUS       = 3;
  localparam int unsigned SRC_USE       = 4;
  localparam int unsigned SRC_FIRST_IRQ = 5;
endpackage

// File: rtl/esc_rst_sync.sv
module esc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_n = q2;
endmodule

// File: rtl/esc_src_cell.sv
module esc_src_cell (
  input  logic clk,
  input  logic srst_n,
  input  logic set_i,
  input  logic enter_i,
  input  logic exit_i,
  output logic pend_o,
  output logic act_o
);
  logic pend_q, act_q, pend_n, act_n;

  // A new request outranks a same-cycle entry: the source becomes active-and-pending.
  always_comb begin
    pend_n = (pend_q & ~enter_i) | set_i;
    act_n  = (act_q & ~exit_i) | enter_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/esc_arbiter.sv
module esc_arbiter #(
  parameter int N    = 9,
  parameter int IW   = 4,
  parameter int RW   = 4,
  parameter int BASE = 10
) (
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    act,
  input  logic [N-1:0]    elig,
  input  logic [N*RW-1:0] rank,
  output logic            win_valid,
  output logic [IW-1:0]   win_id,
  output logic [RW-1:0]   win_rank,
  output logic [RW-1:0]   exec_rank
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_rank  = RW'(BASE);
    exec_rank = RW'(BASE);
    // Ascending scan with strict compare keeps the lower index on a tie.
    for (int i = 0; i < N; i++) begin
      if (pend[i] && elig[i] && (!win_valid || rank[i*RW +: RW] < win_rank)) begin
        win_valid = 1'b1;
        win_id    = IW'(i);
        win_rank  = rank[i*RW +: RW];
      end
      if (act[i] && rank[i*RW +: RW] < exec_rank) begin
        exec_rank = rank[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl #(
  parameter int NUM_IRQ = 4,
  parameter int PW      = 3,
  localparam int N      = 5 + NUM_IRQ,
  localparam int IW     = $clog2(N),
  localparam int RW     = PW + 1,
  localparam int BASE   = (2 ** PW) + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    hw_req,
  input  logic [N-1:0]    sw_set,
  input  logic            xn_fetch,
  input  logic            prot_en,
  input  logic [N-1:0]    src_en,
  input  logic [N*PW-1:0] prio,
  input  logic            entry_stb,
  input  logic [IW-1:0]   entry_id,
  input  logic            ret_stb,
  input  logic [IW-1:0]   ret_id,
  output logic [2*N-1:0]  state,
  output logic            win_valid,
  output logic [IW-1:0]   win_id,
  output logic            preempt_req,
  output logic [RW-1:0]   exec_rank,
  output logic            reset_entry
);
  import esc_pkg::*;

  logic            srst_n;
  logic [N-1:0]    raw_req, set_vec, enter_vec, exit_vec, elig, pend, act;
  logic [N*RW-1:0] rank;
  logic            escalate;
  logic [RW-1:0]   win_rank;
  logic            done_q, done_n;

  esc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // Request routing, fault escalation, eligibility and ranks.
  always_comb begin
    raw_req          = hw_req | sw_set;
    raw_req[SRC_MEM] = (hw_req[SRC_MEM] & prot_en) | xn_fetch | sw_set[SRC_MEM];
    escalate         = 1'b0;
    set_vec          = raw_req;
    for (int f = SRC_MEM; f <= SRC_USE; f++) begin
      set_vec[f] = raw_req[f] & src_en[f];
      escalate   = escalate | (raw_req[f] & ~src_en[f]);
    end
    set_vec[SRC_HARD] = raw_req[SRC_HARD] | escalate;
    elig              = src_en;
    elig[SRC_NMI]     = 1'b1;
    elig[SRC_HARD]    = 1'b1;
    for (int i = 0; i < N; i++) begin
      rank[i*RW +: RW] = RW'(prio[i*PW +: PW]) + RW'(2);
      enter_vec[i]     = entry_stb && (entry_id == IW'(i));
      exit_vec[i]      = ret_stb && (ret_id == IW'(i));
    end
    rank[SRC_NMI*RW +: RW]  = RW'(0);
    rank[SRC_HARD*RW +: RW] = RW'(1);
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    esc_src_cell u_cell (
      .clk    (clk),
      .srst_n (srst_n),
      .set_i  (set_vec[g]),
      .enter_i(enter_vec[g]),
      .exit_i (exit_vec[g]),
      .pend_o (pend[g]),
      .act_o  (act[g])
    );
    assign state[2*g +: 2] = {act[g], pend[g]};
  end

  esc_arbiter #(.N(N), .IW(IW), .RW(RW), .BASE(BASE)) u_arb (
    .pend     (pend),
    .act      (act),
    .elig     (elig),
    .rank     (rank),
    .win_valid(win_valid),
    .win_id   (win_id),
    .win_rank (win_rank),
    .exec_rank(exec_rank)
  );

  assign preempt_req = win_valid && (win_rank < exec_rank);

  // Reset handler start strobe.
  always_comb done_n = 1'b1;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= done_n;
  end

  assign reset_entry = srst_n & ~done_q;
endmodule

// File: rtl/esc_ctrl_chk.sv
module esc_ctrl_chk #(
  parameter int N    = 9,
  parameter int IW   = 4,
  parameter int RW   = 4,
  parameter int BASE = 10
) (
  input logic           clk,
  input logic           srst_n,
  input logic [N-1:0]   hw_req,
  input logic [N-1:0]   src_en,
  input logic           entry_stb,
  input logic           ret_stb,
  input logic [IW-1:0]  ret_id,
  input logic [2*N-1:0] state,
  input logic           win_valid,
  input logic [IW-1:0]  win_id,
  input logic           preempt_req,
  input logic [RW-1:0]  exec_rank,
  input logic           reset_entry
);
  logic [N-1:0] pb, ab;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      pb[i] = state[2*i];
      ab[i] = state[2*i+1];
    end
  end

  AST_PREEMPT_HAS_WIN: assert property (@(posedge clk) disable iff (!srst_n)
    preempt_req |-> win_valid); // R8
  AST_EXEC_BASE_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (ab == '0) |-> (exec_rank == RW'(BASE))); // R8
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid |-> pb[win_id]); // R7
  AST_NMI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!srst_n)
    ab[0] |-> !preempt_req); // R9
  AST_RET_CLEARS_ACT: assert property (@(posedge clk) disable iff (!srst_n)
    (ret_stb && !entry_stb && (int'(ret_id) < N)) |=> !ab[$past(ret_id)]); // R5
  AST_BUS_ESCALATES: assert property (@(posedge clk) disable iff (!srst_n)
    (hw_req[3] && !src_en[3]) |=> pb[1]); // R10
  AST_ENTRY_ONCE: assert property (@(posedge clk) disable iff (!srst_n)
    reset_entry |=> !reset_entry); // R12
endmodule

bind esc_ctrl esc_ctrl_chk #(.N(N), .IW(IW), .RW(RW), .BASE(BASE)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .hw_req     (hw_req),
  .src_en     (src_en),
  .entry_stb  (entry_stb),
  .ret_stb    (ret_stb),
  .ret_id     (ret_id),
  .state      (state),
  .win_valid  (win_valid),
  .win_id     (win_id),
  .preempt_req(preempt_req),
  .exec_rank  (exec_rank),
  .reset_entry(reset_entry)
);

// File: tb/esc_ctrl_tb.sv
module esc_ctrl_tb;
  localparam int N  = 9;
  localparam int PW = 3;
  localparam int IW = 4;
  localparam int RW = 4;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    hw_req, sw_set, src_en;
  logic            xn_fetch, prot_en, entry_stb, ret_stb;
  logic [N*PW-1:0] prio;
  logic [IW-1:0]   entry_id, ret_id;
  logic [2*N-1:0]  state;
  logic            win_valid, preempt_req, reset_entry;
  logic [IW-1:0]   win_id;
  logic [RW-1:0]   exec_rank;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  esc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set),
    .xn_fetch(xn_fetch), .prot_en(prot_en), .src_en(src_en), .prio(prio),
    .entry_stb(entry_stb), .entry_id(entry_id), .ret_stb(ret_stb), .ret_id(ret_id),
    .state(state), .win_valid(win_valid), .win_id(win_id),
    .preempt_req(preempt_req), .exec_rank(exec_rank), .reset_entry(reset_entry)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic int st(int i);
    return int'(state[2*i +: 2]);
  endfunction

  task automatic set_prio(int i, int p);
    prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic pulse_hw(int i);
    @(negedge clk); hw_req[i] = 1'b1;
    @(negedge clk); hw_req = '0;
  endtask

  task automatic pulse_sw(int i);
    @(negedge clk); sw_set[i] = 1'b1;
    @(negedge clk); sw_set = '0;
  endtask

  task automatic pulse_xn();
    @(negedge clk); xn_fetch = 1'b1;
    @(negedge clk); xn_fetch = 1'b0;
  endtask

  task automatic enter(int i);
    @(negedge clk); entry_stb = 1'b1; entry_id = IW'(i);
    @(negedge clk); entry_stb = 1'b0;
  endtask

  task automatic leave(int i);
    @(negedge clk); ret_stb = 1'b1; ret_id = IW'(i);
    @(negedge clk); ret_stb = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      enter(i);
      leave(i);
    end
  endtask

  task automatic t_reset();
    int pulses = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (reset_entry) pulses++;
    end
    chk("R12", "reset_entry cycles", pulses, 1);
    chk("R1", "state after reset", int'(state), 0);
    chk("R8", "exec_rank idle", int'(exec_rank), 10);
    chk("R8", "no preempt idle", int'(preempt_req), 0);
  endtask

  task automatic t_basic();
    set_prio(5, 3);
    pulse_hw(5);
    chk("R2", "irq5 pending", st(5), 1);
    chk("R7", "win irq5", int'(win_id), 5);
    chk("R8", "preempt from idle", int'(preempt_req), 1);
    pulse_sw(5);
    chk("R2", "irq5 still pending", st(5), 1);
    enter(5);
    chk("R4", "irq5 active", st(5), 2);
    chk("R8", "exec_rank irq5", int'(exec_rank), 5);
    pulse_hw(5);
    chk("R3", "irq5 active-and-pending", st(5), 3);
    chk("R8", "equal rank no preempt", int'(preempt_req), 0);
    leave(5);
    chk("R5", "return to pending", st(5), 1);
    enter(5);
    leave(5);
    chk("R5", "return to inactive", st(5), 0);
  endtask

  task automatic t_nest();
    set_prio(6, 1);
    set_prio(7, 4);
    pulse_hw(7);
    enter(7);
    chk("R6", "exec outer", int'(exec_rank), 6);
    pulse_hw(6);
    chk("R8", "more urgent preempts", int'(preempt_req), 1);
    chk("R7", "win irq6", int'(win_id), 6);
    enter(6);
    chk("R6", "outer still active", st(7), 2);
    chk("R6", "inner active", st(6), 2);
    chk("R6", "exec inner", int'(exec_rank), 3);
    leave(6);
    chk("R6", "exec back to outer", int'(exec_rank), 6);
    leave(7);
    chk("R8", "exec base again", int'(exec_rank), 10);
  endtask

  task automatic t_tie();
    set_prio(5, 2);
    set_prio(8, 2);
    @(negedge clk); hw_req[5] = 1'b1; hw_req[8] = 1'b1;
    @(negedge clk); hw_req = '0;
    chk("R7", "tie lower index", int'(win_id), 5);
    src_en[5] = 1'b0;
    @(negedge clk);
    chk("R7", "disabled skipped", int'(win_id), 8);
    chk("R7", "disabled stays pending", st(5), 1);
    src_en[5] = 1'b1;
    clear_all();
  endtask

  task automatic t_nmi();
    set_prio(5, 0);
    pulse_hw(5);
    enter(5);
    chk("R8", "exec rank prio0", int'(exec_rank), 2);
    pulse_hw(0);
    chk("R9", "nmi wins", int'(win_id), 0);
    chk("R9", "nmi preempts", int'(preempt_req), 1);
    enter(0);
    chk("R9", "exec nmi", int'(exec_rank), 0);
    pulse_sw(1);
    chk("R9", "hard fault pending", st(1), 1);
    chk("R9", "no preempt over nmi", int'(preempt_req), 0);
    pulse_sw(0);
    chk("R3", "nmi active-and-pending", st(0), 3);
    leave(0);
    chk("R5", "nmi back to pending", st(0), 1);
    clear_all();
  endtask

  task automatic t_esc();
    src_en[3] = 1'b0;
    pulse_hw(3);
    chk("R10", "disabled bus fault idle", st(3), 0);
    chk("R10", "hard fault pending", st(1), 1);
    chk("R10", "hard fault wins", int'(win_id), 1);
    src_en[3] = 1'b1;
    pulse_hw(3);
    chk("R10", "enabled bus fault pending", st(3), 1);
    src_en[4] = 1'b0;
    clear_all();
    pulse_sw(4);
    chk("R10", "disabled usage fault idle", st(4), 0);
    chk("R10", "usage escalates", st(1), 1);
    src_en[4] = 1'b1;
    clear_all();
  endtask

  task automatic t_mem();
    prot_en = 1'b0;
    pulse_hw(2);
    chk("R11", "access fault gated", st(2), 0);
    pulse_xn();
    chk("R11", "xn fetch pends", st(2), 1);
    clear_all();
    prot_en = 1'b1;
    pulse_hw(2);
    chk("R11", "access fault counted", st(2), 1);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0;
    hw_req = '0; sw_set = '0; src_en = '1;
    xn_fetch = 1'b0; prot_en = 1'b1;
    entry_stb = 1'b0; ret_stb = 1'b0; entry_id = '0; ret_id = '0;
    prio = '1;
    t_reset();
    t_basic();
    t_nest();
    t_tie();
    t_nmi();
    t_esc();
    t_mem();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule